// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox Controller

This block lets any core of a multi-core system interrupt any other core and hand it a short message. It sits on a shared 32-bit register bus. Every core has a pair of registers in the block: a control register that it writes, and a status register that it reads.

A core signals another core by writing its own control register. The write names the destination core and carries a 16-bit payload. The block stores the sender's core number and the payload in the destination's status register and raises that core's interrupt. The interrupt is level-sensitive and stays asserted until the receiving core writes the acknowledge bit to its own control register.

The block has no interrupt inputs: messages come only from bus writes. The core count, the address width and the bus byte order are parameters.

Top module: `ipi_mailbox_ctrl`

## Requirements
- R1: Core c's control register sits at byte address 8*c and its status register at 8*c+4. Address bits 1:0 are ignored. Address bits above bit 2 give the core index.
- R2: With BUS_BIG_ENDIAN=1, the byte order of each bus word is reversed relative to the register value, on both writes and reads: bus bits 7:0 carry register bits 31:24, and so on down to bus bits 31:24, which carry register bits 7:0. With BUS_BIG_ENDIAN=0 the bus word is the register value.
- R3: A write to core S's control register with bit 30 (generate) set and bits 29:16 (destination D) below NCORES does three things from the next clock edge: it sets D's pending flag, it stores S as D's source, and it stores bits 15:0 as D's payload.
- R4: A write to core C's control register with bit 31 (acknowledge) set clears C's pending flag from the next edge. C's source and payload are kept.
- R5: When one write sets both acknowledge and generate, the acknowledge is applied first and the generate second. A core that targets itself therefore stays pending, with the new source and payload.
- R6: A generate to a core that is already pending replaces the stored source and payload, and the flag stays set.
- R7: The following writes change no state: a generate whose destination is at or above NCORES, any write to a status register, any write to an address whose core index is at or above NCORES, and a control write with neither bit 31 nor bit 30 set.
- R8: A read returns data one cycle later, on bus_rdata_o. For a status register the value is {bit 31 = 0, bit 30 = pending, bits 29:16 = source, bits 15:0 = payload}. A control register or an unimplemented address reads as zero. In any cycle that follows a cycle with no read, bus_rdata_o is zero.
- R9: irq_o[c] is high exactly while core c's pending flag is set. It holds from cycle to cycle until an acknowledge arrives.
- R10: Reset (rst_ni low, asynchronous) clears every pending flag, source, payload and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data, in bus byte order |
| bus_rdata_o | output | 32 | Registered read data, in bus byte order |
| irq_o | output | NCORES | Level interrupt, one per core |

## Verification
The assertions assume one bus access per cycle, with its select, write enable, address and data stable around the clock edge. They also assume that reset is released only away from a clock edge. The bench changes all bus inputs on the falling edge and releases reset there too, so every access is sampled cleanly at the following rising edge. Destinations at or above the core count, status-register writes and addresses past the last core are driven on purpose, to test the ignore rules within those assumptions.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   localparam int REG_W  = 32;
   localparam int SRC_W  = 14;
   localparam int DATA_W = 16;

   // control word as seen by the block after byte-order correction
   typedef struct packed {
      logic              ack;
      logic              gen;
      logic [SRC_W-1:0]  dst;
      logic [DATA_W-1:0] payload;
   } ctl_word_t;

   // status word returned on a read
   typedef struct packed {
      logic              rsvd;
      logic              pend;
      logic [SRC_W-1:0]  src;
      logic [DATA_W-1:0] payload;
   } stat_word_t;

endpackage

// File: rtl/ipi_lane_swap.sv
module ipi_lane_swap #(
   parameter bit SWAP = 1'b1
) (
   input  logic [ipi_pkg::REG_W-1:0] d_i,
   output logic [ipi_pkg::REG_W-1:0] d_o
);
   localparam int NBYTES = ipi_pkg::REG_W / 8;

   generate
      if (SWAP) begin : g_swap
         for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign d_o[8*b +: 8] = d_i[8*(NBYTES-1-b) +: 8];
         end
      end else begin : g_pass
         assign d_o = d_i;
      end
   endgenerate

endmodule

// File: rtl/ipi_decode.sv
module ipi_decode #(
   parameter int NCORES = 4,
   parameter int ADDR_W = 8,
   localparam int IDX_W = ADDR_W - 3
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        sel_i,
   input  logic                        we_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  ipi_pkg::ctl_word_t          word_i,
   output logic [NCORES-1:0]           ack_o,
   output logic [NCORES-1:0]           gen_o,
   output logic [ipi_pkg::SRC_W-1:0]   src_o,
   output logic [ipi_pkg::DATA_W-1:0]  payload_o,
   output logic                        rd_hit_o,
   output logic [IDX_W-1:0]            idx_o
);
   import ipi_pkg::*;

   logic [IDX_W-1:0] idx;
   logic             is_stat;
   logic             core_ok;
   logic             ctl_wr;
   logic [1:0]       unused_lo;

   assign unused_lo = addr_i[1:0];
   assign idx       = addr_i[ADDR_W-1:3];
   assign is_stat   = addr_i[2];
   assign core_ok   = 32'(idx) < NCORES;
   assign ctl_wr    = sel_i && we_i && !is_stat && core_ok;
   assign rd_hit_o  = sel_i && !we_i && is_stat && core_ok;
   assign idx_o     = idx;
   assign src_o     = SRC_W'(idx);
   assign payload_o = word_i.payload;

   generate
      for (genvar c = 0; c < NCORES; c++) begin : g_strobe
         assign ack_o[c] = ctl_wr && word_i.ack && (idx == IDX_W'(c));
         assign gen_o[c] = ctl_wr && word_i.gen && (word_i.dst == SRC_W'(c));
      end
   endgenerate

   // R7
   gen_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gen_o));

   // R7
   stat_wr_no_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && we_i && is_stat) |-> (gen_o == '0 && ack_o == '0));

endmodule

// File: rtl/ipi_slot.sv
module ipi_slot (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        ack_i,
   input  logic                        gen_i,
   input  logic [ipi_pkg::SRC_W-1:0]   src_i,
   input  logic [ipi_pkg::DATA_W-1:0]  payload_i,
   output logic                        pend_o,
   output logic [ipi_pkg::SRC_W-1:0]   src_o,
   output logic [ipi_pkg::DATA_W-1:0]  payload_o
);
   import ipi_pkg::*;

   logic              pend_q;
   logic [SRC_W-1:0]  src_q;
   logic [DATA_W-1:0] payload_q;

   // the generate of the same write lands after the acknowledge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q    <= 1'b0;
         src_q     <= '0;
         payload_q <= '0;
      end else if (gen_i) begin
         pend_q    <= 1'b1;
         src_q     <= src_i;
         payload_q <= payload_i;
      end else if (ack_i) begin
         pend_q    <= 1'b0;
      end
   end

   assign pend_o    = pend_q;
   assign src_o     = src_q;
   assign payload_o = payload_q;

   // R3
   gen_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gen_i |=> pend_o);

   // R6
   gen_stores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gen_i |=> (payload_o == $past(payload_i) && src_o == $past(src_i)));

   // R4
   ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !gen_i) |=> !pend_o);

   // R9
   level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o && !ack_i) |=> pend_o);

endmodule

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl #(
   parameter int NCORES         = 4,
   parameter int ADDR_W         = 8,
   parameter bit BUS_BIG_ENDIAN = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               bus_sel_i,
   input  logic               bus_we_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [31:0]        bus_wdata_i,
   output logic [31:0]        bus_rdata_o,
   output logic [NCORES-1:0]  irq_o
);
   import ipi_pkg::*;

   localparam int IDX_W = ADDR_W - 3;

   generate
      if (NCORES < 1 || NCORES > (1 << SRC_W)) begin : g_bad_cores
         $error("NCORES out of range");
      end
      if (ADDR_W < 4 || (1 << IDX_W) < NCORES) begin : g_bad_addr
         $error("ADDR_W too small for NCORES");
      end
   endgenerate

   logic [REG_W-1:0]  wr_word;
   logic [NCORES-1:0] ack, gen;
   logic [SRC_W-1:0]  gen_src;
   logic [DATA_W-1:0] gen_payload;
   logic              rd_hit;
   logic [IDX_W-1:0]  rd_idx;
   logic [NCORES-1:0] pend;
   logic [SRC_W-1:0]  src_q     [NCORES];
   logic [DATA_W-1:0] payload_q [NCORES];
   stat_word_t        rd_word;
   logic [REG_W-1:0]  rd_bus;
   logic [REG_W-1:0]  rdata_q;

   ipi_lane_swap #(.SWAP(BUS_BIG_ENDIAN)) u_wswap (
      .d_i (bus_wdata_i),
      .d_o (wr_word)
   );

   ipi_decode #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_dec (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     (bus_sel_i),
      .we_i      (bus_we_i),
      .addr_i    (bus_addr_i),
      .word_i    (ctl_word_t'(wr_word)),
      .ack_o     (ack),
      .gen_o     (gen),
      .src_o     (gen_src),
      .payload_o (gen_payload),
      .rd_hit_o  (rd_hit),
      .idx_o     (rd_idx)
   );

   generate
      for (genvar c = 0; c < NCORES; c++) begin : g_slot
         ipi_slot u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .ack_i     (ack[c]),
            .gen_i     (gen[c]),
            .src_i     (gen_src),
            .payload_i (gen_payload),
            .pend_o    (pend[c]),
            .src_o     (src_q[c]),
            .payload_o (payload_q[c])
         );
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int c = 0; c < NCORES; c++) begin
         if (rd_idx == IDX_W'(c)) begin
            rd_word.pend    = pend[c];
            rd_word.src     = src_q[c];
            rd_word.payload = payload_q[c];
         end
      end
   end

   ipi_lane_swap #(.SWAP(BUS_BIG_ENDIAN)) u_rswap (
      .d_i (rd_word),
      .d_o (rd_bus)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rdata_q <= '0;
      else if (rd_hit) rdata_q <= rd_bus;
      else             rdata_q <= '0;
   end

   assign bus_rdata_o = rdata_q;
   assign irq_o       = pend;

   // R8
   rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_sel_i && !bus_we_i) |=> (bus_rdata_o == '0));

   // R7
   stat_wr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && bus_we_i && bus_addr_i[2]) |=> $stable(irq_o));

endmodule

// File: tb/sim_ipi_mailbox_ctrl.sv
`timescale 1ns/1ps
module sim_ipi_mailbox_ctrl;
   localparam int NC = 4;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] irq;

   int  nchecks = 0;
   int  nfail = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   ipi_mailbox_ctrl #(.NCORES(NC), .ADDR_W(AW), .BUS_BIG_ENDIAN(1'b1)) u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_sel_i   (bus_sel),
      .bus_we_i    (bus_we),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .irq_o       (irq)
   );

   function automatic logic [31:0] bswap(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   function automatic logic [31:0] ctl(input bit a, input bit g, input int dst, input logic [15:0] p);
      logic [13:0] d;
      d = dst[13:0];
      return {a, g, d, p};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int          m_pend [NC];
   int          m_src  [NC];
   int          m_data [NC];
   logic [31:0] m_rd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NC; i++) begin
            m_pend[i] = 0; m_src[i] = 0; m_data[i] = 0;
         end
         m_rd = 0;
      end else begin
         int core, off, d;
         logic [31:0] r;
         m_rd = 0;
         core = int'(bus_addr) / 8;
         off  = int'(bus_addr) % 8;
         r    = bswap(bus_wdata);
         if (bus_sel && !bus_we && core < NC && off >= 4)
            m_rd = (m_pend[core] << 30) | (m_src[core] << 16) | m_data[core];
         if (bus_sel && bus_we && core < NC && off < 4) begin
            if (r[31]) m_pend[core] = 0;
            d = int'(r[29:16]);
            if (r[30] && d < NC) begin
               m_pend[d] = 1;
               m_src[d]  = core;
               m_data[d] = int'(r[15:0]);
            end
         end
      end
   end

   // compare on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NC-1:0] e;
         for (int i = 0; i < NC; i++) e[i] = (m_pend[i] != 0);
         chk(irq == e, "R9 irq vs model", 32'(irq), 32'(e));
         chk(bswap(bus_rdata) == m_rd, "R8 rdata vs model", bswap(bus_rdata), m_rd);
      end
   end

   task automatic wr(input int a, input logic [31:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = bswap(v);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] v, output logic [31:0] raw);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
      @(negedge clk);
      raw = bus_rdata;
      v = bswap(raw);
      bus_sel = 1'b0;
   endtask

   task automatic rdchk(input int a, input logic [31:0] exp, input string tag);
      logic [31:0] v, raw;
      rd(a, v, raw);
      chk(v == exp, tag, v, exp);
   endtask

   task automatic finish_up();
      $display("  End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nfail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         finish_up();
      end
   end

   initial begin
      logic [31:0] v, raw;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(irq == '0, "R10 irq in reset", 32'(irq), 0);
      chk(bus_rdata == '0, "R10 rdata in reset", bus_rdata, 0);
      rst_n = 1'b1;

      rdchk(4, 32'h0, "R10 stat0 after reset");

      // core1 -> core2
      wr(8, ctl(0, 1, 2, 16'hBEEF));
      chk(irq == 4'b0100, "R3 irq after generate", 32'(irq), 32'h4);
      rdchk(20, 32'h4001BEEF, "R3 R1 stat2 contents");
      rd(20, v, raw);
      chk(raw == 32'hEFBE0140, "R2 bus byte order", raw, 32'hEFBE0140);
      rdchk(23, 32'h4001BEEF, "R1 low address bits ignored");
      rdchk(16, 32'h0, "R8 control reads zero");

      // overwrite while pending
      wr(24, ctl(0, 1, 2, 16'h1234));
      chk(irq == 4'b0100, "R6 still pending", 32'(irq), 32'h4);
      rdchk(20, 32'h40031234, "R6 overwrite source and payload");

      // acknowledge
      wr(16, ctl(1, 0, 0, 0));
      chk(irq == 4'b0000, "R4 irq cleared", 32'(irq), 0);
      rdchk(20, 32'h00031234, "R4 source and payload kept");

      // ignored writes
      wr(0, ctl(0, 1, 4, 16'h7777));
      chk(irq == 4'b0000, "R7 destination out of range", 32'(irq), 0);
      wr(0, ctl(0, 1, 16'h3FFF, 16'h7777));
      chk(irq == 4'b0000, "R7 destination max", 32'(irq), 0);
      wr(4, 32'hFFFFFFFF);
      rdchk(4, 32'h0, "R7 status write ignored");
      wr(32, ctl(1, 1, 1, 16'h5A5A));
      chk(irq == 4'b0000, "R7 unimplemented core write", 32'(irq), 0);
      wr(8, ctl(0, 0, 3, 16'h9999));
      chk(irq == 4'b0000, "R7 no command bits", 32'(irq), 0);
      rdchk(28, 32'h0, "R7 stat3 untouched");
      rdchk(36, 32'h0, "R8 unimplemented reads zero");

      // ack plus generate
      wr(0, ctl(0, 1, 0, 16'h1111));
      chk(irq == 4'b0001, "R3 self generate", 32'(irq), 32'h1);
      wr(0, ctl(1, 1, 0, 16'hAAAA));
      chk(irq == 4'b0001, "R5 self ack+gen stays pending", 32'(irq), 32'h1);
      rdchk(4, 32'h4000AAAA, "R5 self ack+gen new payload");
      wr(0, ctl(1, 1, 3, 16'h5555));
      chk(irq == 4'b1000, "R5 ack own, raise other", 32'(irq), 32'h8);
      rdchk(28, 32'h40005555, "R5 stat3 contents");

      // level holds
      repeat (5) @(negedge clk);
      chk(irq == 4'b1000, "R9 level held", 32'(irq), 32'h8);

      // reset mid-run
      wr(8, ctl(0, 1, 1, 16'hC0DE));
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(irq == '0, "R10 irq cleared by reset", 32'(irq), 0);
      rst_n = 1'b1;
      rdchk(28, 32'h0, "R10 stat3 cleared");
      rdchk(12, 32'h0, "R10 stat1 cleared");

      repeat (2) @(negedge clk);
      done = 1'b1;
      finish_up();
   end

endmodule